// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block is the register-level controller for an eight-input, 10-bit successive-approximation converter that sits on a small byte-wide processor bus. Software enables the converter, picks an input channel, and sets a start bit. The block then performs a 10-step binary search. On each step it drives a trial code to an external DAC and reads back a single comparator bit. When the search is done, it publishes the result into two read-only registers and raises a sticky done flag. That flag can request an interrupt.

Each search step takes one tick of an internal prescaler, so the converter clock can be kept below its maximum rate for any system clock. When the enable bit is clear, the converter is in standby: a start request is refused, and clearing enable in the middle of a conversion abandons it.

The sequencer is a three-state machine:
- S_IDLE waits for a start request. Transition T_LAUNCH goes to S_CONV when a start request is accepted.
- S_CONV steps the search once per prescaler tick. Transition T_FINISH goes to S_DONE on the tick that decides bit 0. Transition T_ABORT returns to S_IDLE when enable reads 0.
- S_DONE lasts one cycle. It writes the result, sets the done flag and clears the start bit. Transition T_PUBLISH returns to S_IDLE.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `dac_code` is 0, `adc_power` is 0 and `mux_sel` is 0.
- R2: Register map: address 0 is the control register, with bit0 enable, bit1 start, bit2 done flag, bit3 interrupt enable and bits 6:4 channel. Address 1 holds the divider N in bits 4:0. Address 2 holds result bits 9:2. Address 3 holds result bits 1:0 in its bits 1:0, with bits 7:2 reading 0. A control write with bit1=1 and bit0=1 in S_IDLE starts a conversion. Start reads 1 during the conversion, and hardware clears it when the conversion ends.
- R3: A control write with bit0=0 never starts a conversion. Start stays 0, the done flag is not set, and `adc_power` follows bit0.
- R4: The done flag and both result registers change on the same clock edge. The flag stays 1 until a control write with bit2=0 clears it. A write with bit2=1 leaves the flag unchanged.
- R5: `irq` is 1 exactly when the done flag and the interrupt enable are both 1. Clearing the flag drops `irq` and re-arms it for the next conversion.
- R6: `mux_sel` takes the binary channel field (000 is input 0, 111 is input 7) at the moment a start is accepted. It holds that value until the next start, even if the field is rewritten during a conversion.
- R7: The search runs MSB first. Each step sets the trial bit and keeps it when `cmp_in` is 1 (input at or above the DAC code), or clears it otherwise. An input above full scale therefore gives 0x3FF, and an input below zero gives 0x000.
- R8: One search step occurs every 2×N system clocks, and N=0 acts as N=1. The done flag reads 1 exactly 10×2×max(N,1)+1 clock edges after the edge that accepted the start.
- R9: Clearing enable during a conversion aborts it. Start returns to 0, the done flag and result registers keep their previous values, and the block returns to S_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_in | input | 1 | Comparator result: 1 when the input is at or above `dac_code` |
| dac_code | output | 10 | Trial code driven to the DAC |
| mux_sel | output | 3 | Analog multiplexer channel select |
| adc_power | output | 1 | 1 powers the converter, 0 is standby |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check the following on every cycle:
- S_DONE is always followed by a set flag and a clear start bit.
- The done flag never drops without a clearing write.
- An abort leaves the result stable.
- The latched channel does not move during S_CONV.
- Prescaler ticks are never adjacent.
- Each search step moves the code in the direction the comparator chose.

Only the bench scenarios can show the exact end-to-end conversion latency for each divider value, the final codes including saturation at both ends, the refused start in standby, and the interplay of the interrupt enable with the flag's write-1-has-no-effect rule.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_CONV = 2'd1,
        S_DONE = 2'd2
    } seq_state_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_DIV  = 2'd1;
    localparam logic [1:0] A_RHI  = 2'd2;
    localparam logic [1:0] A_RLO  = 2'd3;

    localparam int B_EN    = 0;
    localparam int B_START = 1;
    localparam int B_EOC   = 2;
    localparam int B_IE    = 3;
    localparam int B_CH_LO = 4;

endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim = (div_n == '0) ? CNT_W'(2) : {div_n, 1'b0};
    end

    assign tick = run && (cnt_q == lim - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the period is at least two clocks, so ticks never come back to back
    assert_tick_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] code,
    output logic             last
);
    localparam int IDX_W = $clog2(RES_W);

    logic [IDX_W-1:0] idx_q;
    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] code_nxt;

    always_comb begin
        code_nxt = code_q;
        code_nxt[idx_q] = cmp_in;
        if (idx_q != '0) begin
            code_nxt[idx_q - 1'b1] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            idx_q  <= '0;
        end else if (load) begin
            code_q <= {1'b1, {(RES_W-1){1'b0}}};
            idx_q  <= IDX_W'(RES_W - 1);
        end else if (step) begin
            code_q <= code_nxt;
            if (idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    assign code = code_q;
    assign last = (idx_q == '0);

    // R7: a rejected trial always lowers the code, an accepted one never does
    assert_step_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !cmp_in) |=> (code_q < $past(code_q)));
    assert_step_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && cmp_in) |=> (code_q >= $past(code_q)));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CH_W  = 3,
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_addr,
    input  logic             bus_we,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [CH_W-1:0]  mux_sel,
    output logic             adc_power,
    output logic             irq
);
    localparam int LO_W = RES_W - 8;

    seq_state_t state_q, state_nxt;

    logic             en_q, ie_q, start_q, eoc_q;
    logic [CH_W-1:0]  ch_q, ch_lat_q;
    logic [DIV_W-1:0] div_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] sar_code;
    logic             sar_last, tick;
    logic             ctrl_wr, div_wr, start_acc, step;

    assign ctrl_wr   = bus_we && (bus_addr == A_CTRL);
    assign div_wr    = bus_we && (bus_addr == A_DIV);
    assign start_acc = ctrl_wr && bus_wdata[B_START] && bus_wdata[B_EN]
                       && (state_q == S_IDLE);
    assign step      = tick && en_q && (state_q == S_CONV);

    adc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == S_CONV),
        .div_n (div_q),
        .tick  (tick)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_acc),
        .step   (step),
        .cmp_in (cmp_in),
        .code   (sar_code),
        .last   (sar_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nxt;
    end

    // Transitions: T_LAUNCH, T_ABORT, T_FINISH, T_PUBLISH
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            S_IDLE: if (start_acc) state_nxt = S_CONV;
            S_CONV: begin
                if (!en_q)                 state_nxt = S_IDLE;
                else if (tick && sar_last) state_nxt = S_DONE;
            end
            S_DONE: state_nxt = S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Register and flag updates driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            ie_q     <= 1'b0;
            start_q  <= 1'b0;
            eoc_q    <= 1'b0;
            ch_q     <= '0;
            ch_lat_q <= '0;
            div_q    <= '0;
            res_q    <= '0;
        end else begin
            if (ctrl_wr) begin
                en_q <= bus_wdata[B_EN];
                ie_q <= bus_wdata[B_IE];
                ch_q <= bus_wdata[B_CH_LO +: CH_W];
                if (!bus_wdata[B_EOC]) eoc_q <= 1'b0;
            end
            if (div_wr) div_q <= bus_wdata[DIV_W-1:0];
            if (start_acc) begin
                start_q  <= 1'b1;
                ch_lat_q <= bus_wdata[B_CH_LO +: CH_W];
            end
            if (state_q == S_CONV && !en_q) start_q <= 1'b0;
            if (state_q == S_DONE) begin
                start_q <= 1'b0;
                eoc_q   <= 1'b1;
                res_q   <= sar_code;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL: bus_rdata = {1'b0, ch_q, ie_q, eoc_q, start_q, en_q};
            A_DIV:  bus_rdata[DIV_W-1:0] = div_q;
            A_RHI:  bus_rdata = res_q[RES_W-1:LO_W];
            A_RLO:  bus_rdata[LO_W-1:0] = res_q[LO_W-1:0];
            default: bus_rdata = '0;
        endcase
    end

    assign dac_code  = sar_code;
    assign mux_sel   = ch_lat_q;
    assign adc_power = en_q;
    assign irq       = eoc_q && ie_q;

    assert_done_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> eoc_q);
    assert_done_clears_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |=> !start_q);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_q && !(ctrl_wr && !bus_wdata[B_EOC])) |=> eoc_q);
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV && !en_q) |=> (state_q == S_IDLE && !start_q && $stable(res_q)));
    assert_standby_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !(ctrl_wr && bus_wdata[B_EN])) |=> (state_q == S_IDLE));
    assert_chan_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CONV) |=> $stable(ch_lat_q));
    assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state_q == S_DONE) || $past(ctrl_wr)));

endmodule

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic [2:0] mux_sel;
    logic       adc_power;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done_run = 1'b0;
    int vin [8];

    always #4 clk = ~clk;

    adc_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .mux_sel(mux_sel), .adc_power(adc_power), .irq(irq)
    );

    // analog model: comparator on the selected input
    always_comb cmp_in = (vin[mux_sel] >= int'(dac_code));

    // {channel[2:0], divider[4:0], input[11:0] signed}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {3'd0, 5'd0,  12'h155},
        {3'd7, 5'd1,  12'h3FF},
        {3'd3, 5'd3,  12'h44C},
        {3'd5, 5'd2,  12'hFFB},
        {3'd1, 5'd31, 12'h200},
        {3'd2, 5'd0,  12'h001},
        {3'd6, 5'd4,  12'h2AA},
        {3'd4, 5'd1,  12'h1FF}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    function automatic logic [7:0] ctl(input int ch, input bit ie, input bit eoc,
                                       input bit st, input bit en);
        return {1'b0, 3'(ch), ie, eoc, st, en};
    endfunction

    // cycles until the done flag reads 1 (start accepted on the previous write)
    task automatic wait_eoc(output int n);
        logic [7:0] r;
        n = 0;
        rd(2'd0, r);
        while (!r[2] && n < 3000) begin
            @(posedge clk); #1; n++;
            rd(2'd0, r);
        end
    endtask

    function automatic int clampv(input int v);
        if (v > 1023) return 1023;
        if (v < 0) return 0;
        return v;
    endfunction

    task automatic read_result(output int res);
        logic [7:0] hi, lo;
        rd(2'd2, hi);
        rd(2'd3, lo);
        chk("R2 low register upper bits zero", int'(lo[7:2]), 0);
        res = int'({hi, lo[1:0]});
    endtask

    initial begin
        #(8 * 150000);
        chk("watchdog expired", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int n, res, prev;
        foreach (vin[i]) vin[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk("R1 register reset", int'(r), 0);
        end
        chk("R1 irq reset", int'(irq), 0);
        chk("R1 dac reset", int'(dac_code), 0);
        chk("R1 power reset", int'(adc_power), 0);
        chk("R1 mux reset", int'(mux_sel), 0);

        // table of conversions
        for (int k = 0; k < NV; k++) begin
            int ch, dv, v, lim;
            ch = int'(VEC[k][19:17]);
            dv = int'(VEC[k][16:12]);
            v  = int'($signed(VEC[k][11:0]));
            lim = 2 * ((dv == 0) ? 1 : dv);
            vin[ch] = v;
            wr(2'd1, 8'(dv));
            rd(2'd1, r);
            chk("R2 divider readback", int'(r), dv);
            wr(2'd0, ctl(ch, 1, 0, 1, 1));
            rd(2'd0, r);
            chk("R2 start reads 1 while converting", int'(r[1]), 1);
            chk("R6 mux follows channel", int'(mux_sel), ch);
            chk("R3 power on when enabled", int'(adc_power), 1);
            wait_eoc(n);
            chk("R8 conversion latency", n, 10 * lim + 1);
            rd(2'd0, r);
            chk("R2 start cleared at end", int'(r[1]), 0);
            read_result(res);
            chk("R7 result value", res, clampv(v));
            chk("R5 irq with flag and enable", int'(irq), 1);
            wr(2'd0, ctl(ch, 1, 0, 0, 1));
            chk("R5 irq drops after clear", int'(irq), 0);
        end

        // R4 write-1 to flag does not clear; R5 interrupt enable gating
        vin[2] = 700;
        wr(2'd1, 8'd0);
        wr(2'd0, ctl(2, 0, 0, 1, 1));
        // R6 rewrite channel mid-conversion: mux must hold 2
        wr(2'd0, ctl(5, 0, 0, 1, 1));
        chk("R6 channel held during conversion", int'(mux_sel), 2);
        wait_eoc(n);
        chk("R5 no irq with enable 0", int'(irq), 0);
        read_result(res);
        chk("R6 result from latched channel", res, 700);
        wr(2'd0, ctl(2, 1, 1, 0, 1));
        rd(2'd0, r);
        chk("R4 flag survives write of 1", int'(r[2]), 1);
        chk("R5 irq once enabled with flag set", int'(irq), 1);
        repeat (5) @(posedge clk);
        #1 rd(2'd0, r);
        chk("R4 flag stays set", int'(r[2]), 1);
        wr(2'd0, ctl(2, 0, 0, 0, 1));
        rd(2'd0, r);
        chk("R4 flag cleared by write of 0", int'(r[2]), 0);

        // R3 standby: start refused
        wr(2'd0, ctl(3, 1, 0, 1, 0));
        chk("R3 power off in standby", int'(adc_power), 0);
        repeat (40) @(posedge clk);
        #1 rd(2'd0, r);
        chk("R3 start stays 0 in standby", int'(r[1]), 0);
        chk("R3 no done flag in standby", int'(r[2]), 0);
        read_result(res);
        chk("R3 result untouched in standby", res, 700);

        // R9 abort
        prev = 700;
        vin[4] = 100;
        wr(2'd1, 8'd5);
        wr(2'd0, ctl(4, 1, 0, 1, 1));
        repeat (30) @(posedge clk);
        #1 wr(2'd0, ctl(4, 1, 0, 0, 0));
        repeat (3) @(posedge clk);
        #1 rd(2'd0, r);
        chk("R9 start cleared on abort", int'(r[1]), 0);
        chk("R9 flag unchanged on abort", int'(r[2]), 0);
        read_result(res);
        chk("R9 result unchanged on abort", res, prev);
        wr(2'd0, ctl(4, 1, 0, 0, 1));
        repeat (150) @(posedge clk);
        #1 rd(2'd0, r);
        chk("R9 no resume after re-enable", int'(r[2]), 0);
        chk("R9 no irq after abort", int'(irq), 0);

        done_run = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule